// File: doc/BRIEF.md
# Dynamic Bit-Array Access and Refresh Sequencer

This block drives a behavioural 1024 x 1 dynamic storage array laid out as 32 rows of 32 columns. A host request carries a 10-bit address, a write enable, a chip select and one data bit. Every access runs through three fixed phases: a precharge phase, an address-decode phase and a select phase. While the sequencer works, a busy flag is raised and one strobe per phase is shown, together with the one-hot row lines and column gates.

A free-running interval timer queues a refresh request each time it expires. A refresh is a read sequence with chip select held off, aimed at the row named by an internal counter. One such cycle takes as long as a host cycle. The interval is set in clock cycles, so that the 32 rows are all visited within the retention period. A refresh takes precedence over a host request that is waiting in the idle state. No host data moves while a refresh runs.

Top module: `dram_seq_top`

## Requirements
- R1: The address splits into row = addr_i[9:5] and column = addr_i[4:0]. A completed write with chip select high stores din_i at that location, and a later read with chip select high returns it.
- R2: ack_o is high in an idle cycle in which req_i is high and no refresh is pending, and the access is accepted at that edge. While busy_o is high, ack_o stays low and req_i has no effect.
- R3: After acceptance the phases run in a fixed order: PRE_CYC cycles with pre_o high, then ADR_CYC cycles with adr_o high, then SEL_CYC cycles with sel_o high. While pre_o is high, every row line and every column gate is low.
- R4: In a host cycle, during adr_o and sel_o, row_line_o is one-hot at bit addr[9:5] and col_gate_o is one-hot at bit addr[4:0]. Address 0 selects bit 0 of both.
- R5: busy_o is high from the cycle after acceptance through the last select cycle, and low in the cycle after that.
- R6: A write takes effect at the end of the select phase, and only with chip select high. A write with chip select low leaves the stored bit unchanged.
- R7: A read with chip select high loads dout_o at the end of the select phase. A read with chip select low leaves dout_o unchanged.
- R8: Each refresh cycle has the same phases and length as a host cycle. refresh_o is high throughout it, col_gate_o stays all zero, and neither stored data nor dout_o changes.
- R9: A refresh request is queued every REF_INT cycles and wins over a waiting host request. Even under back-to-back host traffic, consecutive refresh starts lie between REF_INT - CYC_LEN and REF_INT + CYC_LEN cycles apart.
- R10: The refresh row counter starts at 0 after reset, advances by one after each refresh cycle, and wraps from 31 to 0. The refreshed row shows as the one-hot row_line_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request level |
| we_i | input | 1 | 1 = write, 0 = read |
| cs_i | input | 1 | Chip select, connects the external data path |
| addr_i | input | 10 | Row in bits 9:5, column in bits 4:0 |
| din_i | input | 1 | Write data |
| ack_o | output | 1 | Request accepted this cycle |
| busy_o | output | 1 | Sequencer running a host or refresh cycle |
| pre_o | output | 1 | Precharge phase strobe |
| adr_o | output | 1 | Address-decode phase strobe |
| sel_o | output | 1 | Select phase strobe |
| refresh_o | output | 1 | Current cycle is a refresh |
| row_line_o | output | 32 | One-hot row lines |
| col_gate_o | output | 32 | One-hot column gates |
| dout_o | output | 1 | Registered read data |

## Verification
The bench builds the block with REF_INT = 40 and phase lengths 2, 1 and 2, so each cycle takes 5 clocks. With those values, refreshes interleave with host traffic every few accesses. The counter passes its 31-to-0 wrap more than once in a few thousand cycles. Host requests that are held high during busy periods press on the refresh priority bound.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_ADR  = 2'd2,
    PH_SEL  = 2'd3
  } phase_e;
endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int unsigned REF_INT = 6250,
  parameter int unsigned ROW_W   = 5,
  localparam int unsigned TW     = $clog2(REF_INT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_start_i,
  input  logic             ref_done_i,
  output logic             ref_pend_o,
  output logic [ROW_W-1:0] ref_row_o
);
  logic [TW-1:0] tmr_q;
  logic          expire;

  assign expire = (tmr_q == TW'(REF_INT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q      <= '0;
      ref_pend_o <= 1'b0;
      ref_row_o  <= '0;
    end else begin
      tmr_q      <= expire ? '0 : tmr_q + 1'b1;
      ref_pend_o <= expire | (ref_pend_o & ~ref_start_i);
      if (ref_done_i) ref_row_o <= ref_row_o + 1'b1;
    end
  end

  a_r10_row_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_done_i |=> ref_row_o == $past(ref_row_o) + 1'b1);
  a_r9_pend_on_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> ref_pend_o);
endmodule

// File: rtl/dram_phase_fsm.sv
module dram_phase_fsm
  import dram_seq_pkg::*;
#(
  parameter int unsigned ROW_W   = 5,
  parameter int unsigned COL_W   = 5,
  parameter int unsigned PRE_CYC = 2,
  parameter int unsigned ADR_CYC = 1,
  parameter int unsigned SEL_CYC = 2,
  localparam int unsigned MAXC   = (PRE_CYC > ADR_CYC) ?
                                   ((PRE_CYC > SEL_CYC) ? PRE_CYC : SEL_CYC) :
                                   ((ADR_CYC > SEL_CYC) ? ADR_CYC : SEL_CYC),
  localparam int unsigned CW     = $clog2(MAXC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             cs_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             din_i,
  input  logic             ref_pend_i,
  input  logic [ROW_W-1:0] ref_row_i,
  output phase_e           phase_o,
  output logic             ack_o,
  output logic             ref_start_o,
  output logic             done_o,
  output logic             is_ref_o,
  output logic             we_o,
  output logic             cs_o,
  output logic             din_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o
);
  phase_e        st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len;
  logic          last;

  always_comb begin
    unique case (st_q)
      PH_PRE:  len = CW'(PRE_CYC);
      PH_ADR:  len = CW'(ADR_CYC);
      PH_SEL:  len = CW'(SEL_CYC);
      default: len = CW'(1);
    endcase
  end

  assign last        = (cnt_q == len - 1'b1);
  assign ref_start_o = (st_q == PH_IDLE) & ref_pend_i;
  assign ack_o       = (st_q == PH_IDLE) & ~ref_pend_i & req_i;
  assign done_o      = (st_q == PH_SEL) & last;
  assign phase_o     = st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PH_IDLE: if (ref_start_o || ack_o) st_d = PH_PRE;
      PH_PRE:  if (last) st_d = PH_ADR;
      PH_ADR:  if (last) st_d = PH_SEL;
      PH_SEL:  if (last) st_d = PH_IDLE;
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= PH_IDLE;
      cnt_q    <= '0;
      is_ref_o <= 1'b0;
      we_o     <= 1'b0;
      cs_o     <= 1'b0;
      din_o    <= 1'b0;
      row_o    <= '0;
      col_o    <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= (st_q == PH_IDLE || last) ? '0 : cnt_q + 1'b1;
      if (ref_start_o) begin
        is_ref_o <= 1'b1;
        we_o     <= 1'b0;
        cs_o     <= 1'b0;
        row_o    <= ref_row_i;
        col_o    <= '0;
      end else if (ack_o) begin
        is_ref_o <= 1'b0;
        we_o     <= we_i;
        cs_o     <= cs_i;
        din_o    <= din_i;
        row_o    <= row_i;
        col_o    <= col_i;
      end
    end
  end

  a_r2_ack_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> st_q == PH_PRE && !is_ref_o);
  a_r9_ref_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !ref_pend_i);
  a_r3_pre_to_adr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PH_PRE && last) |=> st_q == PH_ADR);
  a_r3_adr_to_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PH_ADR && last) |=> st_q == PH_SEL);
endmodule

// File: rtl/dram_bit_array.sv
module dram_bit_array
  import dram_seq_pkg::*;
#(
  parameter int unsigned ROW_W = 5,
  parameter int unsigned COL_W = 5,
  localparam int unsigned ROWS  = 1 << ROW_W,
  localparam int unsigned COLS  = 1 << COL_W,
  localparam int unsigned CELLS = ROWS * COLS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  phase_e           phase_i,
  input  logic             done_i,
  input  logic             is_ref_i,
  input  logic             we_i,
  input  logic             cs_i,
  input  logic             din_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  output logic [ROWS-1:0]  row_line_o,
  output logic [COLS-1:0]  col_gate_o,
  output logic             dout_o
);
  logic [CELLS-1:0] mem_q;
  logic             drive;
  logic             host_sel;

  assign drive    = (phase_i == PH_ADR) || (phase_i == PH_SEL);
  assign host_sel = done_i & ~is_ref_i & cs_i;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_line_o[r] = drive && (row_i == ROW_W'(r));
  end
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_gate_o[c] = drive && !is_ref_i && (col_i == COL_W'(c));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q  <= '0;
      dout_o <= 1'b0;
    end else if (host_sel) begin
      if (we_i) mem_q[{row_i, col_i}] <= din_i;
      else      dout_o <= mem_q[{row_i, col_i}];
    end
  end

  a_r3_pre_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i == PH_PRE |-> row_line_o == '0 && col_gate_o == '0);
  a_r4_row_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive |-> $onehot(row_line_o));
  a_r8_ref_no_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ref_i && phase_i != PH_IDLE |-> col_gate_o == '0);
  a_r8_ref_dout_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && is_ref_i |=> $stable(dout_o));
  a_r7_cs_off_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !cs_i |=> $stable(dout_o));
endmodule

// File: rtl/dram_seq_top.sv
module dram_seq_top
  import dram_seq_pkg::*;
#(
  parameter int unsigned ROW_W   = 5,
  parameter int unsigned COL_W   = 5,
  parameter int unsigned PRE_CYC = 2,
  parameter int unsigned ADR_CYC = 1,
  parameter int unsigned SEL_CYC = 2,
  parameter int unsigned REF_INT = 6250,
  localparam int unsigned AW     = ROW_W + COL_W,
  localparam int unsigned ROWS   = 1 << ROW_W,
  localparam int unsigned COLS   = 1 << COL_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic            cs_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            din_i,
  output logic            ack_o,
  output logic            busy_o,
  output logic            pre_o,
  output logic            adr_o,
  output logic            sel_o,
  output logic            refresh_o,
  output logic [ROWS-1:0] row_line_o,
  output logic [COLS-1:0] col_gate_o,
  output logic            dout_o
);
  phase_e           phase;
  logic             ref_pend, ref_start, done, is_ref;
  logic             l_we, l_cs, l_din;
  logic [ROW_W-1:0] ref_row, l_row;
  logic [COL_W-1:0] l_col;

  dram_ref_timer #(.REF_INT(REF_INT), .ROW_W(ROW_W)) u_timer (
    .clk_i, .rst_ni,
    .ref_start_i (ref_start),
    .ref_done_i  (done & is_ref),
    .ref_pend_o  (ref_pend),
    .ref_row_o   (ref_row)
  );

  dram_phase_fsm #(
    .ROW_W(ROW_W), .COL_W(COL_W),
    .PRE_CYC(PRE_CYC), .ADR_CYC(ADR_CYC), .SEL_CYC(SEL_CYC)
  ) u_fsm (
    .clk_i, .rst_ni, .req_i, .we_i, .cs_i,
    .row_i       (addr_i[AW-1:COL_W]),
    .col_i       (addr_i[COL_W-1:0]),
    .din_i,
    .ref_pend_i  (ref_pend),
    .ref_row_i   (ref_row),
    .phase_o     (phase),
    .ack_o,
    .ref_start_o (ref_start),
    .done_o      (done),
    .is_ref_o    (is_ref),
    .we_o        (l_we),
    .cs_o        (l_cs),
    .din_o       (l_din),
    .row_o       (l_row),
    .col_o       (l_col)
  );

  dram_bit_array #(.ROW_W(ROW_W), .COL_W(COL_W)) u_array (
    .clk_i, .rst_ni,
    .phase_i   (phase),
    .done_i    (done),
    .is_ref_i  (is_ref),
    .we_i      (l_we),
    .cs_i      (l_cs),
    .din_i     (l_din),
    .row_i     (l_row),
    .col_i     (l_col),
    .row_line_o,
    .col_gate_o,
    .dout_o
  );

  assign busy_o    = (phase != PH_IDLE);
  assign pre_o     = (phase == PH_PRE);
  assign adr_o     = (phase == PH_ADR);
  assign sel_o     = (phase == PH_SEL);
  assign refresh_o = busy_o & is_ref;

  a_r5_busy_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> busy_o);
  a_r2_no_ack_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ack_o);
  a_r3_one_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $onehot({pre_o, adr_o, sel_o}));
  a_r5_idle_after_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sel_o) |-> !busy_o);
endmodule

// File: tb/dram_seq_top_bench.sv
module dram_seq_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int REF_INT    = 40;
  localparam int CYC_LEN    = 5;
  localparam int WDOG       = 150000;

  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0, cs = 0, din = 0;
  logic [9:0]  addr = '0;
  logic        ack, busy, pre, adr, sel, refr, dout;
  logic [31:0] row_line, col_gate;

  int total = 0, bad = 0, cyc = 0;
  bit model [1024];
  bit exp_dout = 0;
  int exp_row = 0, ref_cnt = 0, last_start = -1;
  bit prev_ref = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_seq_top #(.PRE_CYC(2), .ADR_CYC(1), .SEL_CYC(2), .REF_INT(REF_INT)) u_dram_seq_top (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .cs_i(cs),
    .addr_i(addr), .din_i(din), .ack_o(ack), .busy_o(busy), .pre_o(pre),
    .adr_o(adr), .sel_o(sel), .refresh_o(refr), .row_line_o(row_line),
    .col_gate_o(col_gate), .dout_o(dout)
  );

  task automatic chk(input bit ok, input string req_tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req_tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] one(input int b);
    return 32'h1 << b;
  endfunction

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, WDOG);
      finish_run();
    end
    if (rst_n) begin
      if (refr && !prev_ref) begin
        if (last_start >= 0)  // R9 gap bound
          chk((cyc - last_start) >= REF_INT - CYC_LEN && (cyc - last_start) <= REF_INT + CYC_LEN,
              "R9", cyc - last_start, REF_INT);
        last_start = cyc;
      end
      if (refr && adr) begin  // R10 row sequence, R8 no column
        chk(row_line == one(exp_row), "R10", row_line, one(exp_row));
        chk(col_gate == 0, "R8", col_gate, 0);
        chk(dout == exp_dout, "R8", dout, exp_dout);
        exp_row = (exp_row + 1) % 32;
        ref_cnt++;
      end
      prev_ref = refr;
    end
  end

  task automatic op(input bit w, input bit c, input logic [9:0] a, input bit d);
    @(negedge clk);
    req = 1; we = w; cs = c; addr = a; din = d;
    #1;
    while (!ack) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
    for (int k = 1; k <= CYC_LEN; k++) begin
      // hold a conflicting request during busy: R2
      req = (k < CYC_LEN); we = 1; cs = 1; din = ~d; addr = ~a;
      #1;
      chk(busy == 1, "R5", busy, 1);
      chk(ack == 0, "R2", ack, 0);
      if (k <= 2) begin
        chk(pre && row_line == 0 && col_gate == 0, "R3", {pre, row_line}, {1'b1, 32'h0});
      end else if (k == 3) begin
        chk(adr, "R3", adr, 1);
        chk(row_line == one(a[9:5]) && col_gate == one(a[4:0]), "R4", {row_line, col_gate},
            {one(a[9:5]), one(a[4:0])});
      end else begin
        chk(sel && col_gate == one(a[4:0]), "R3", sel, 1);
      end
      @(negedge clk);
    end
    req = 0;
    #1;
    chk(busy == 0, "R5", busy, 0);
    if (w && c) model[a] = d;
    if (!w && c) begin
      exp_dout = model[a];
      chk(dout == exp_dout, "R1", dout, exp_dout);
    end else if (!w) begin
      chk(dout == exp_dout, "R7", dout, exp_dout);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD*3);
    @(negedge clk);
    chk(busy == 0 && dout == 0 && ack == 0 && row_line == 0, "R5", busy, 0);
    rst_n = 1;
    // directed corners
    op(1, 1, 10'd0, 1);          // R4 address zero
    op(0, 1, 10'd0, 0);          // R1
    op(1, 1, 10'h3ff, 1);
    op(0, 1, 10'h3ff, 0);
    op(1, 0, 10'd0, 0);          // R6 cs low write ignored
    op(0, 1, 10'd0, 0);
    chk(dout == 1, "R6", dout, 1);
    op(0, 1, 10'h155, 0);        // loads 0
    op(0, 0, 10'h3ff, 0);        // R7 cs low read keeps dout
    chk(dout == 0, "R7", dout, 0);
    for (int i = 0; i < 300; i++) begin
      logic [9:0] a = 10'($urandom_range(0, 1023));
      if (i % 3 == 0) a = {5'($urandom_range(0, 3)), 5'($urandom_range(0, 3))};
      op(1'($urandom), ($urandom_range(0, 7) != 0), a, 1'($urandom));
    end
    chk(ref_cnt >= 33, "R10", ref_cnt, 33);  // wrap covered
    finish_run();
  end
endmodule